// File: doc/BRIEF.md
# I2C Controller Transmit/Receive FIFO Pair

This block holds the two data queues of an I2C controller. The transmit queue is 16 entries of 10 bits: an 8-bit byte and two control bits that the bus engine reads. Register writes fill it and the engine drains it. The receive queue is 16 entries of 8 bits. The engine fills it and register reads drain it. Both queues report their fill level through flags and through zero-based occupancy counts. For an empty queue, the count reads 0 and the empty flag tells the two cases apart.

Three level events drive the controller's interrupt logic: the receive queue has reached a programmable threshold, the transmit queue is empty, and the transmit queue is at most half full. The threshold is written as the wanted byte count minus one. A control level flushes the transmit queue and keeps it empty. A write into a full transmit queue is dropped and raises a sticky overflow indication. A read from an empty receive queue changes nothing and returns the previous byte again.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Each queue holds 16 entries; `tx_full`/`rx_full` are high exactly when 16 entries are stored.
- R2: Both queues are first-in first-out: `tx_head` shows the oldest transmit entry, and `rx_rdata` loads the oldest receive byte on the clock edge where `rx_rd` is sampled high.
- R3: `tx_occ`/`rx_occ` equal the entry count minus one when the queue is not empty, and 0 when it is empty.
- R4: Empty and full flags and occupancy reflect a push or pop right after the clock edge that performs it, with no further delay.
- R5: A write with `thr_wr` stores `thr_val` as the threshold minus one (reset value 0). `ev_rx_thresh` is high while the receive entry count is at least `thr_val`+1.
- R6: `ev_tx_empty` is high while the transmit queue holds 0 entries. `ev_tx_half` is high while it holds 8 or fewer entries.
- R7: While `tx_flush` is high, the transmit queue is emptied and held empty, transmit writes are ignored, and `tx_ovf` is cleared.
- R8: A transmit write into a full queue is dropped, leaves the contents unchanged, and sets `tx_ovf`. `tx_ovf` stays high until a flush or a reset.
- R9: A read of an empty receive queue moves no pointer and leaves `rx_rdata` holding its last value. A byte pushed afterwards is the next one read.
- R10: An engine pop of an empty transmit queue, and an engine push into a full receive queue, are ignored.
- R11: After reset both queues are empty, both occupancies are 0, `tx_ovf` is 0, the threshold is 0 and `rx_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_flush | input | 1 | Holds the transmit queue empty while high |
| tx_wr | input | 1 | Register write into the transmit queue |
| tx_wdata | input | 10 | Transmit entry (byte plus two control bits) |
| tx_pop | input | 1 | Engine removes the transmit head |
| tx_head | output | 10 | Oldest transmit entry |
| rx_push | input | 1 | Engine stores a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_rd | input | 1 | Register read of the receive queue |
| rx_rdata | output | 8 | Byte returned by the last receive read |
| thr_wr | input | 1 | Load the receive threshold |
| thr_val | input | 4 | Threshold minus one |
| tx_occ | output | 4 | Transmit occupancy, zero-based |
| rx_occ | output | 4 | Receive occupancy, zero-based |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_ovf | output | 1 | Sticky dropped-write indication |
| ev_rx_thresh | output | 1 | Receive threshold reached |
| ev_tx_empty | output | 1 | Transmit queue empty event |
| ev_tx_half | output | 1 | Transmit queue at most half full |

## Verification
If an entry count goes wrong, the occupancy and the three events disagree with a reference count in the very next cycle. Reference queues kept beside the block track both counts independently. A wrong pointer shows up at `tx_head` before the affected pop, or at `rx_rdata` one edge after the read, because every value that comes out is compared with the reference queue. An underflow or overflow leaves a pointer out of step with the count. The bench looks for this by draining each queue completely after the boundary case and checking that the data order survives.

// File: rtl/i2cfp_pkg.sv
package i2cfp_pkg;

  // zero-based occupancy: an empty queue and a single entry both read 0
  function automatic int unsigned occ_zero_based(input int unsigned entries);
    return (entries == 0) ? 0 : entries - 1;
  endfunction

  // threshold is stored as (wanted count - 1)
  function automatic logic level_reached(input int unsigned entries,
                                         input int unsigned thr_m1);
    return entries >= thr_m1 + 1;
  endfunction

  function automatic logic at_most_half(input int unsigned entries,
                                        input int unsigned depth);
    return entries <= depth / 2;
  endfunction

endpackage

// File: rtl/i2cfp_fifo.sv
module i2cfp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty && !clr;
  assign do_push = push && !full && !clr;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R8: a push into a full queue without a pop leaves the level unchanged
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && $stable(count)));

  // R10: a pop of an empty queue without a push leaves it empty
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

  // R1: the level never exceeds the depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/i2cfp_events.sv
module i2cfp_events
  import i2cfp_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]   tx_count,
  input  logic [$clog2(DEPTH+1)-1:0]   rx_count,
  input  logic [$clog2(DEPTH)-1:0]     rx_thr_m1,
  output logic                         ev_rx_thresh,
  output logic                         ev_tx_empty,
  output logic                         ev_tx_half
);
  assign ev_rx_thresh = level_reached(int'(rx_count), int'(rx_thr_m1));
  assign ev_tx_empty  = (tx_count == '0);
  assign ev_tx_half   = at_most_half(int'(tx_count), DEPTH);

  // R6: an empty queue is always also at most half full
  assert_empty_implies_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_empty |-> ev_tx_half);

endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2cfp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TX_W  = 10,
  parameter int RX_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tx_flush,
  input  logic                        tx_wr,
  input  logic [TX_W-1:0]             tx_wdata,
  input  logic                        tx_pop,
  output logic [TX_W-1:0]             tx_head,
  input  logic                        rx_push,
  input  logic [RX_W-1:0]             rx_wdata,
  input  logic                        rx_rd,
  output logic [RX_W-1:0]             rx_rdata,
  input  logic                        thr_wr,
  input  logic [$clog2(DEPTH)-1:0]    thr_val,
  output logic [$clog2(DEPTH)-1:0]    tx_occ,
  output logic [$clog2(DEPTH)-1:0]    rx_occ,
  output logic                        tx_full,
  output logic                        tx_empty,
  output logic                        rx_full,
  output logic                        rx_empty,
  output logic                        tx_ovf,
  output logic                        ev_rx_thresh,
  output logic                        ev_tx_empty,
  output logic                        ev_tx_half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]   tx_count, rx_count;
  logic [RX_W-1:0] rx_head;
  logic [AW-1:0]   rx_thr_m1;
  logic            tx_drop;   // write lost because the queue was full
  logic            rx_take;   // read that actually removes a byte

  i2cfp_fifo #(.W(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_flush),
    .push(tx_wr), .pop(tx_pop), .wdata(tx_wdata),
    .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  i2cfp_fifo #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(1'b0),
    .push(rx_push), .pop(rx_rd), .wdata(rx_wdata),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  i2cfp_events #(.DEPTH(DEPTH)) u_ev (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_count), .rx_count(rx_count), .rx_thr_m1(rx_thr_m1),
    .ev_rx_thresh(ev_rx_thresh), .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half)
  );

  assign tx_drop = tx_wr && tx_full && !tx_flush;
  assign rx_take = rx_rd && !rx_empty;
  assign tx_occ  = AW'(occ_zero_based(int'(tx_count)));
  assign rx_occ  = AW'(occ_zero_based(int'(rx_count)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_thr_m1 <= '0;
      rx_rdata  <= '0;
      tx_ovf    <= 1'b0;
    end else begin
      if (thr_wr)  rx_thr_m1 <= thr_val;
      if (rx_take) rx_rdata  <= rx_head;
      if (tx_flush)     tx_ovf <= 1'b0;
      else if (tx_drop) tx_ovf <= 1'b1;
    end
  end

  // R7: a flush leaves the transmit queue empty and the overflow cleared
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> (tx_empty && !tx_ovf));

  // R8: the overflow indication is sticky until a flush
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_flush) |=> tx_ovf);

  // R9: reading an empty receive queue keeps the returned byte
  assert_empty_read_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |=> $stable(rx_rdata));

  // R5: the threshold event never fires on an empty receive queue
  assert_thresh_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_thresh |-> !rx_empty);

  // R3: zero-based occupancy reads its top value only when full
  assert_occ_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_occ == AW'(DEPTH - 1)) |-> tx_full);

endmodule

// File: tb/tb_i2c_fifo_pair.sv
module tb_i2c_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic tx_flush = 0, tx_wr = 0, tx_pop = 0, rx_push = 0, rx_rd = 0, thr_wr = 0;
  logic [9:0] tx_wdata = '0, tx_head;
  logic [7:0] rx_wdata = '0, rx_rdata;
  logic [3:0] thr_val = '0, tx_occ, rx_occ;
  logic tx_full, tx_empty, rx_full, rx_empty, tx_ovf;
  logic ev_rx_thresh, ev_tx_empty, ev_tx_half;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fifo_pair dut (
    .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .tx_pop(tx_pop), .tx_head(tx_head), .rx_push(rx_push), .rx_wdata(rx_wdata),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .thr_wr(thr_wr), .thr_val(thr_val),
    .tx_occ(tx_occ), .rx_occ(rx_occ), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_full(rx_full), .rx_empty(rx_empty), .tx_ovf(tx_ovf),
    .ev_rx_thresh(ev_rx_thresh), .ev_tx_empty(ev_tx_empty), .ev_tx_half(ev_tx_half)
  );

  int total = 0, bad = 0;

  // reference model
  logic [9:0] tq[$];
  logic [7:0] rq[$];
  logic [7:0] exp_q[$];
  logic [7:0] last_rx = '0;
  int thr = 0;
  bit ovf_m = 0;
  event rd_done;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int zocc(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  task automatic check_tx(input string req);
    chk(req, int'(tx_empty), int'(tq.size() == 0));
    chk(req, int'(tx_full), int'(tq.size() == DEPTH));
    chk(req, int'(tx_occ), zocc(tq.size()));
    chk(req, int'(ev_tx_empty), int'(tq.size() == 0));
    chk(req, int'(ev_tx_half), int'(tq.size() <= DEPTH/2));
    chk(req, int'(tx_ovf), int'(ovf_m));
  endtask

  task automatic check_rx(input string req);
    chk(req, int'(rx_empty), int'(rq.size() == 0));
    chk(req, int'(rx_full), int'(rq.size() == DEPTH));
    chk(req, int'(rx_occ), zocc(rq.size()));
    chk(req, int'(ev_rx_thresh), int'(rq.size() >= thr + 1));
  endtask

  // driver tasks: start and end at a falling edge
  task automatic tx_write(input logic [9:0] d);
    tx_wr = 1; tx_wdata = d;
    @(negedge clk);
    tx_wr = 0;
    if (tq.size() < DEPTH) tq.push_back(d); else ovf_m = 1;
  endtask

  task automatic tx_take(input string req);
    if (tq.size() > 0) chk(req, int'(tx_head), int'(tq[0]));
    tx_pop = 1;
    @(negedge clk);
    tx_pop = 0;
    if (tq.size() > 0) void'(tq.pop_front());
  endtask

  task automatic tx_both(input logic [9:0] d);
    tx_wr = 1; tx_pop = 1; tx_wdata = d;
    @(negedge clk);
    tx_wr = 0; tx_pop = 0;
    void'(tq.pop_front());
    tq.push_back(d);
  endtask

  task automatic flush(input bit with_write);
    tx_flush = 1; tx_wr = with_write; tx_wdata = 10'h3FF;
    @(negedge clk);
    tx_flush = 0; tx_wr = 0;
    tq.delete(); ovf_m = 0;
  endtask

  task automatic rx_put(input logic [7:0] d);
    rx_push = 1; rx_wdata = d;
    @(negedge clk);
    rx_push = 0;
    if (rq.size() < DEPTH) rq.push_back(d);
  endtask

  task automatic rx_get();
    logic [7:0] e;
    e = (rq.size() > 0) ? rq.pop_front() : last_rx;
    last_rx = e;
    exp_q.push_back(e);
    rx_rd = 1;
    @(negedge clk);
    rx_rd = 0;
    -> rd_done;
  endtask

  task automatic set_thr(input int v);
    thr_wr = 1; thr_val = 4'(v);
    @(negedge clk);
    thr_wr = 0; thr = v;
  endtask

  // monitor: compares each read result against the scoreboard queue
  initial begin
    forever begin
      @(rd_done);
      if (exp_q.size() > 0) chk("R2 R9 rx_rdata", int'(rx_rdata), int'(exp_q.pop_front()));
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    check_tx("R11");
    check_rx("R11");
    chk("R11 rx_rdata", int'(rx_rdata), 0);

    // R3 R4: single entry reads zero-based 0 but not empty
    tx_write(10'h155);
    check_tx("R3 R4");
    chk("R2 head", int'(tx_head), 10'h155);

    // R1 R6: fill to the top, checking levels along the way
    for (int i = 1; i < DEPTH; i++) begin
      tx_write(10'(10'h100 + i * 7));
      check_tx("R1 R6");
    end
    // R8: write into full queue is dropped and sets overflow
    tx_write(10'h2AA);
    check_tx("R8");

    // R2: drain in order
    for (int i = 0; i < DEPTH; i++) begin
      tx_take("R2 tx order");
      check_tx("R6");
    end
    // R10: pop of empty ignored
    tx_take("R10");
    check_tx("R10");
    tx_write(10'h011);
    tx_write(10'h022);
    check_tx("R8 sticky");
    chk("R10 head after empty pop", int'(tx_head), 10'h011);

    // simultaneous push and pop keeps the level
    tx_both(10'h033);
    check_tx("R4 push+pop");
    chk("R2 head after push+pop", int'(tx_head), 10'h022);

    // R7: flush with a write in the same cycle
    flush(1);
    check_tx("R7");
    tx_write(10'h0C3);
    check_tx("R7 after flush");
    chk("R7 head after flush", int'(tx_head), 10'h0C3);
    tx_take("R7 drain");

    // R5: default threshold 0 means one byte
    rx_put(8'hA1);
    check_rx("R5 default");
    rx_get();
    check_rx("R5");
    set_thr(3);
    for (int i = 0; i < 4; i++) begin
      rx_put(8'(8'h40 + i));
      check_rx("R5 thr=3");
    end
    rx_get();
    check_rx("R5 below");
    for (int i = 0; i < 3; i++) rx_get();
    check_rx("R5 empty");

    // R1 R10: fill receive queue, extra push dropped
    set_thr(15);
    for (int i = 0; i < DEPTH; i++) begin
      rx_put(8'(8'h80 + i * 3));
      check_rx("R1 R3 rx");
    end
    rx_put(8'hEE);
    check_rx("R10 rx full");
    for (int i = 0; i < DEPTH; i++) rx_get();
    check_rx("R2 rx drained");

    // R9: empty read returns last value, then new byte is next
    rx_get();
    check_rx("R9");
    rx_put(8'h5A);
    rx_get();
    check_rx("R9 after");
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule